// File: doc/BRIEF.md
# Energy pulse frequency divider

This block converts a stream of energy-quantum strobes into an active-low output pulse train. The pulse rate is the strobe rate divided by a programmable 16-bit unsigned divisor. Three energy quantities are available, each as a set of per-phase strobes with a sign bit. A 3-bit code chooses the quantity, and a 3-bit phase mask decides which phase strobes are added to the running count. Every enabled strobe counts once, including several that arrive in the same clock cycle.

The output idles high. The time it spends low depends on how fast pulses are coming. When the interval between the two most recent pulses is longer than 160 ms, each pulse is held low for a fixed 80 ms. When the interval is shorter, the low phase is counted in input strobes, which gives a 50% duty for even divisors and (1+1/divisor)×50% for odd divisors. A divisor of 0 behaves exactly like 1, and an effective divisor of 1 always gives a 1 µs low pulse. The block also keeps a reverse-power flag that holds the sign of the most recently counted strobe.

All intervals are counted in clock cycles derived from the `CLK_HZ` parameter. The surrounding chip supplies the strobes, typically from a threshold accumulator, and the configuration comes in as plain inputs.

Top module: `energy_pulse_divider`

## Requirements
- R1: One output pulse starts each time the count of selected, enabled strobes reaches the effective divisor. Strobes beyond the divisor carry over into the next pulse.
- R2: A divisor input of 0 produces exactly the same output as a divisor of 1.
- R3: When the effective divisor is 1, each pulse is low for 1 µs (max(1, CLK_HZ/1e6) cycles), whatever the pulse period.
- R4: When the interval ending at a pulse exceeds 160 ms, that pulse is low for exactly 80 ms. The first pulse after reset counts as slow.
- R5: For a fast pulse (interval ≤ 160 ms) with an even divisor D, the output returns high on the clock edge that registers the D/2-th strobe after the pulse began.
- R6: For a fast pulse with an odd divisor D, the output returns high on the edge that registers the (D+1)/2-th strobe.
- R7: Selector code 3'b000 counts the total active strobes, 3'b100 the fundamental reactive strobes and 3'b010 the apparent strobes. Every other code counts nothing.
- R8: Bit i of the phase mask (bit 0 = phase A, bit 1 = phase B, bit 2 = phase C) admits that phase's strobes. A phase whose bit is clear has no effect on the count or on the flag.
- R9: Strobes from several enabled phases in the same cycle are each counted.
- R10: The reverse flag takes the sign bit (1 = negative) of the highest-numbered counted strobe in a cycle. It is unchanged in cycles in which nothing is counted.
- R11: After reset the output is high and the reverse flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_qty | input | 3 | Quantity selector code |
| phase_en | input | 3 | Per-phase enable mask |
| divisor | input | 16 | Division ratio, 0 treated as 1 |
| act_stb | input | 3 | Total active energy strobes per phase |
| act_neg | input | 3 | Sign of active strobes (1 = negative) |
| rvar_stb | input | 3 | Fundamental reactive energy strobes per phase |
| rvar_neg | input | 3 | Sign of reactive strobes |
| app_stb | input | 3 | Apparent energy strobes per phase |
| app_neg | input | 3 | Sign of apparent strobes |
| pulse_n | output | 1 | Active-low frequency output |
| rev_flag | output | 1 | Sign of the last counted strobe |

## Verification
The bench builds the block with CLK_HZ = 2000, which gives a 1-cycle short pulse, an 80 ms hold of 160 cycles and a slow threshold of 320 cycles. At that rate both the slow-period hold and the counted fast duty fit into a few thousand cycles. It also makes it possible to see a slow first pulse being retriggered into a fast one. The small divisors used (0 to 5) reach the zero-as-one case, even and odd duty spans and residue carry-over.

// File: rtl/epd_pkg.sv
package epd_pkg;
  typedef enum logic [1:0] {LOW_NONE, LOW_TIMED, LOW_COUNTED} low_kind_e;

  localparam logic [2:0] SEL_ACT  = 3'b000;
  localparam logic [2:0] SEL_RVAR = 3'b100;
  localparam logic [2:0] SEL_APP  = 3'b010;

  // Effective divisor: zero is promoted to one.
  function automatic logic [16:0] eff_div(input logic [15:0] d);
    return (d == 16'd0) ? 17'd1 : {1'b0, d};
  endfunction

  // Strobes during which a fast pulse stays low: ceil(e/2).
  function automatic logic [16:0] low_span(input logic [16:0] e);
    return (e + 17'd1) >> 1;
  endfunction
endpackage

// File: rtl/epd_strobe_sel.sv
module epd_strobe_sel #(
  parameter int NPH = 3,
  localparam int CW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     sel_qty,
  input  logic [NPH-1:0] phase_en,
  input  logic [NPH-1:0] act_stb,
  input  logic [NPH-1:0] act_neg,
  input  logic [NPH-1:0] rvar_stb,
  input  logic [NPH-1:0] rvar_neg,
  input  logic [NPH-1:0] app_stb,
  input  logic [NPH-1:0] app_neg,
  output logic [CW-1:0]  inc,
  output logic           rev_flag
);
  import epd_pkg::*;

  logic [NPH-1:0] q_stb, q_neg, counted;
  logic           any_counted, top_neg;

  always_comb begin
    q_stb = '0;
    q_neg = '0;
    case (sel_qty)
      SEL_ACT:  begin q_stb = act_stb;  q_neg = act_neg;  end
      SEL_RVAR: begin q_stb = rvar_stb; q_neg = rvar_neg; end
      SEL_APP:  begin q_stb = app_stb;  q_neg = app_neg;  end
      default:  ;
    endcase
    counted = q_stb & phase_en;
  end

  always_comb begin
    inc     = '0;
    top_neg = 1'b0;
    for (int i = 0; i < NPH; i++) begin
      inc = inc + CW'(counted[i]);
      if (counted[i]) top_neg = q_neg[i];
    end
  end

  assign any_counted = |counted;

  always_ff @(posedge clk) begin
    if (!rst_n)           rev_flag <= 1'b0;
    else if (any_counted) rev_flag <= top_neg;
  end

  // R10: the flag only moves when something was counted
  p_rev_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0) |=> $stable(rev_flag));
endmodule

// File: rtl/epd_accum.sv
module epd_accum #(
  parameter int DIV_W = 16,
  parameter int NPH   = 3,
  localparam int CW    = $clog2(NPH + 1),
  localparam int ACC_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [CW-1:0]    inc,
  output logic             fire,
  output logic [ACC_W-1:0] cnt_next,
  output logic [ACC_W-1:0] eff,
  output logic [ACC_W-1:0] span
);
  import epd_pkg::*;

  localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

  logic [ACC_W-1:0] cnt_q;
  logic [ACC_W:0]   sum, rem;

  assign eff  = ACC_W'(eff_div(divisor));
  assign span = ACC_W'(low_span(eff_div(divisor)));

  always_comb begin
    sum  = {1'b0, cnt_q} + (ACC_W + 1)'(inc);
    fire = (sum >= {1'b0, eff});
    rem  = fire ? (sum - {1'b0, eff}) : sum;
    cnt_next = (rem > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : rem[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  // R1: without strobes and below the divisor the count holds
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0 && cnt_q < eff) |=> (cnt_q == $past(cnt_q)));
  // R1: a pulse needs either new strobes or a carried residue
  p_fire_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (inc != '0 || cnt_q >= eff));
endmodule

// File: rtl/epd_shaper.sv
module epd_shaper #(
  parameter int CLK_HZ = 10_000_000,
  parameter int ACC_W  = 18,
  localparam int US_CYC    = CLK_HZ / 1_000_000,
  localparam int SHORT_CYC = (US_CYC < 1) ? 1 : US_CYC,
  localparam int HOLD_CYC  = (CLK_HZ / 1000) * 80,
  localparam int SLOW_CYC  = (CLK_HZ / 1000) * 160,
  localparam int TW        = $clog2(SLOW_CYC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [ACC_W-1:0] eff,
  input  logic [ACC_W-1:0] span,
  input  logic [ACC_W-1:0] cnt_next,
  output logic             pulse_n
);
  import epd_pkg::*;

  localparam logic [TW-1:0] P_SAT = TW'(SLOW_CYC + 1);

  logic [TW-1:0] per_q;
  logic [TW-1:0] low_q;
  low_kind_e     kind_q;
  logic          period_slow, unit_div;

  assign period_slow = (per_q > TW'(SLOW_CYC));
  assign unit_div    = (eff == ACC_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= P_SAT;
      low_q   <= '0;
      kind_q  <= LOW_NONE;
      pulse_n <= 1'b1;
    end else begin
      if (fire)            per_q <= TW'(1);
      else if (per_q != P_SAT) per_q <= per_q + TW'(1);

      if (fire) begin
        pulse_n <= 1'b0;
        if (unit_div) begin
          kind_q <= LOW_TIMED;
          low_q  <= TW'(SHORT_CYC - 1);
        end else if (period_slow) begin
          kind_q <= LOW_TIMED;
          low_q  <= TW'(HOLD_CYC - 1);
        end else begin
          kind_q <= LOW_COUNTED;
        end
      end else begin
        case (kind_q)
          LOW_TIMED: begin
            if (low_q == '0) begin
              pulse_n <= 1'b1;
              kind_q  <= LOW_NONE;
            end else begin
              low_q <= low_q - TW'(1);
            end
          end
          LOW_COUNTED: begin
            if (cnt_next >= span) begin
              pulse_n <= 1'b1;
              kind_q  <= LOW_NONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: every pulse event drives the output low
  p_fire_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pulse_n);
  // R4: a timed low phase is not cut short
  p_timed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == LOW_TIMED && low_q != '0) |=> !pulse_n);
  // R11: with no low phase pending the output idles high
  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == LOW_NONE && !fire) |=> pulse_n);
endmodule

// File: rtl/energy_pulse_divider.sv
module energy_pulse_divider #(
  parameter int CLK_HZ = 10_000_000,
  parameter int DIV_W  = 16,
  parameter int NPH    = 3,
  localparam int CW    = $clog2(NPH + 1),
  localparam int ACC_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel_qty,
  input  logic [NPH-1:0]   phase_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [NPH-1:0]   act_stb,
  input  logic [NPH-1:0]   act_neg,
  input  logic [NPH-1:0]   rvar_stb,
  input  logic [NPH-1:0]   rvar_neg,
  input  logic [NPH-1:0]   app_stb,
  input  logic [NPH-1:0]   app_neg,
  output logic             pulse_n,
  output logic             rev_flag
);
  import epd_pkg::*;

  logic [CW-1:0]    inc;
  logic             fire;
  logic [ACC_W-1:0] cnt_next, eff, span;
  logic             sel_known;

  epd_strobe_sel #(.NPH(NPH)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_qty(sel_qty), .phase_en(phase_en),
    .act_stb(act_stb), .act_neg(act_neg), .rvar_stb(rvar_stb),
    .rvar_neg(rvar_neg), .app_stb(app_stb), .app_neg(app_neg),
    .inc(inc), .rev_flag(rev_flag)
  );

  epd_accum #(.DIV_W(DIV_W), .NPH(NPH)) u_acc (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .inc(inc),
    .fire(fire), .cnt_next(cnt_next), .eff(eff), .span(span)
  );

  epd_shaper #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W)) u_shp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .eff(eff), .span(span),
    .cnt_next(cnt_next), .pulse_n(pulse_n)
  );

  assign sel_known = (sel_qty == SEL_ACT) || (sel_qty == SEL_RVAR) ||
                     (sel_qty == SEL_APP);

  // R2: divisor zero acts as one, so any counted strobe pulses at once
  p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0 && inc != '0) |=> !pulse_n);
  // R7: unsupported selector codes leave the flag untouched
  p_bad_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_known |=> $stable(rev_flag));
endmodule

// File: tb/energy_pulse_divider_tb.sv
module energy_pulse_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 2000;
  localparam int HOLD = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  sel_qty = 3'b000, phase_en = 3'b111;
  logic [15:0] divisor = 16'd1;
  logic [2:0]  act_stb = '0, act_neg = '0, rvar_stb = '0, rvar_neg = '0;
  logic [2:0]  app_stb = '0, app_neg = '0;
  logic pulse_n, rev_flag;

  int checks = 0, failures = 0;
  int falls = 0, cur_w = 0, last_w = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  energy_pulse_divider #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_qty(sel_qty), .phase_en(phase_en),
    .divisor(divisor), .act_stb(act_stb), .act_neg(act_neg),
    .rvar_stb(rvar_stb), .rvar_neg(rvar_neg), .app_stb(app_stb),
    .app_neg(app_neg), .pulse_n(pulse_n), .rev_flag(rev_flag)
  );

  // Output monitor: low-run starts and width of the last finished run
  always @(negedge clk) begin
    if (!rst_n) begin
      falls = 0; cur_w = 0;
    end else if (!pulse_n) begin
      if (cur_w == 0) falls = falls + 1;
      cur_w = cur_w + 1;
    end else if (cur_w != 0) begin
      last_w = cur_w; cur_w = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // q: 0 active, 1 reactive, 2 apparent; one cycle wide
  task automatic strobe(input int q, input logic [2:0] m, input logic [2:0] ng);
    case (q)
      0: begin act_stb = m; act_neg = ng; end
      1: begin rvar_stb = m; rvar_neg = ng; end
      default: begin app_stb = m; app_neg = ng; end
    endcase
    @(negedge clk);
    act_stb = '0; rvar_stb = '0; app_stb = '0;
    act_neg = '0; rvar_neg = '0; app_neg = '0;
  endtask

  task automatic train(input int q, input logic [2:0] m, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      strobe(q, m, 3'b000);
      idle(gap - 1);
    end
  endtask

  task automatic t_reset_r11();
    do_reset();
    check("R11 idle output", int'(pulse_n), 1);
    check("R11 flag clear", int'(rev_flag), 0);
  endtask

  task automatic t_divide_r1();
    sel_qty = 3'b000; phase_en = 3'b111; divisor = 16'd3;
    do_reset();
    train(0, 3'b001, 10, 150);
    idle(200);
    check("R1 ten strobes div3", falls, 3);
    train(0, 3'b001, 2, 150);
    idle(200);
    check("R1 residue carried", falls, 4);
  endtask

  task automatic t_unit(input logic [15:0] d, input string tag);
    sel_qty = 3'b000; phase_en = 3'b111; divisor = d;
    do_reset();
    train(0, 3'b010, 5, 4);
    idle(20);
    check({tag, " pulse count"}, falls, 5);
    check({tag, " 1us low width"}, last_w, 1);
  endtask

  task automatic t_slow_r4();
    sel_qty = 3'b000; phase_en = 3'b111; divisor = 16'd2;
    do_reset();
    train(0, 3'b001, 4, 200);
    idle(200);
    check("R4 slow pulse count", falls, 2);
    check("R4 80ms low width", last_w, HOLD);
  endtask

  task automatic t_fast(input logic [15:0] d, input int n, input int exp_w, input string tag);
    sel_qty = 3'b000; phase_en = 3'b111; divisor = d;
    do_reset();
    train(0, 3'b001, n, 10);
    idle(50);
    check(tag, last_w, exp_w);
  endtask

  task automatic t_select_r7();
    phase_en = 3'b111; divisor = 16'd1;
    sel_qty = 3'b100; do_reset();
    train(0, 3'b001, 2, 4); idle(5);
    check("R7 active ignored under 100", falls, 0);
    train(1, 3'b001, 2, 4); idle(5);
    check("R7 reactive counted under 100", falls, 2);
    sel_qty = 3'b010; do_reset();
    train(2, 3'b100, 3, 4); train(1, 3'b100, 1, 4); idle(5);
    check("R7 apparent only under 010", falls, 3);
    sel_qty = 3'b111; do_reset();
    train(0, 3'b111, 1, 4); train(1, 3'b111, 1, 4); train(2, 3'b111, 1, 4);
    idle(5);
    check("R7 unsupported code counts nothing", falls, 0);
  endtask

  task automatic t_mask_r8_r9();
    sel_qty = 3'b000; divisor = 16'd1; phase_en = 3'b010;
    do_reset();
    train(0, 3'b101, 3, 4); idle(5);
    check("R8 masked phases ignored", falls, 0);
    train(0, 3'b010, 2, 4); idle(5);
    check("R8 enabled phase counted", falls, 2);
    phase_en = 3'b111; divisor = 16'd3; do_reset();
    strobe(0, 3'b111, 3'b000); idle(5);
    check("R9 three same-cycle strobes reach div3", falls, 1);
    divisor = 16'd4; do_reset();
    strobe(0, 3'b111, 3'b000); idle(5);
    check("R9 three of four counted, no pulse", falls, 0);
    strobe(0, 3'b001, 3'b000); idle(5);
    check("R9 fourth strobe completes", falls, 1);
  endtask

  task automatic t_rev_r10();
    sel_qty = 3'b000; divisor = 16'd100; phase_en = 3'b111;
    do_reset();
    strobe(0, 3'b100, 3'b100);
    check("R10 negative C sets flag", int'(rev_flag), 1);
    phase_en = 3'b011;
    strobe(0, 3'b100, 3'b000);
    check("R10 masked strobe keeps flag", int'(rev_flag), 1);
    strobe(0, 3'b001, 3'b000);
    check("R10 positive A clears flag", int'(rev_flag), 0);
    phase_en = 3'b111;
    strobe(0, 3'b101, 3'b001);
    check("R10 highest phase C positive wins", int'(rev_flag), 0);
    strobe(0, 3'b101, 3'b100);
    check("R10 highest phase C negative wins", int'(rev_flag), 1);
    idle(3);
    check("R10 flag holds without strobes", int'(rev_flag), 1);
  endtask

  initial begin
    t_reset_r11();
    t_divide_r1();
    t_unit(16'd1, "R3");
    t_unit(16'd0, "R2");
    t_slow_r4();
    t_fast(16'd4, 14, 20, "R5 even divisor 50% low width");
    t_fast(16'd5, 18, 30, "R6 odd divisor low width");
    t_select_r7();
    t_mask_r8_r9();
    t_rev_r10();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule